// File: doc/BRIEF.md
# Multi-Channel Saturating PCM Mixer

This block sums audio from five buffered PCM sources and five waveform-generator sources into one stereo output stream. Each PCM source has a small input FIFO. A DMA engine fills it through a write-valid port, and the channel asks for more data through its own request line once the FIFO level drops to a programmed threshold. The waveform-generator sources are sample buses that are always valid and need no buffering. A strobe input, `mix_tick`, marks each mix instant. On a tick, every enabled source adds its current sample, and the saturated left and right sums are pushed into an output FIFO. A consumer drains that FIFO with a request/acknowledge handshake.

Software controls the block through a small word-wide register port. The registers set:
- which sources are enabled,
- which PCM sources deliver stereo pairs,
- a rate divider and a request threshold for each PCM source,
- self-clearing FIFO flush bits,
- the number of output transfers still allowed,
- interrupt enables.

If a PCM source that is enabled is due for a new sample and has none, nothing is mixed for any source on that tick, and a stall flag is raised. The flag stays up until a later tick finds every due source supplied. Sources may be switched on while mixing runs, and doing so leaves the transfer count alone.

Register map (word address on `reg_addr`):
- 0: source enables. Bits 0..4 are the PCM sources; bits 5..9 are the waveform-generator sources.
- 1: stereo select. Bits 0..4, one per PCM source.
- 2: flush. Bits 0..4 empty the PCM FIFOs; bit 5 empties the output FIFO.
- 3: remaining output transfers (16 bits).
- 4: interrupt enables. Bits 0..4 are the per-source request interrupts; bit 5 is the stall interrupt.
- 5: status, read only. Bit 0 is the stall flag.
- 8..12: PCM source 0..4 settings. Bits 3:0 hold the rate divider; bits 11:8 hold the request threshold.

Top module: `pcm_mixer`

## Requirements
- R1: After reset, the source-enable, status and transfer-count registers read 0, and `out_req`, `dma_req` and `irq` are all low.
- R2: The left and right outputs of a tick are the sums of all enabled sources' samples (16-bit two's complement), clamped to the range -32768..32767.
- R3: A PCM source with stereo select 0 takes one FIFO word per sample and uses it for both sides. With stereo select 1 it takes two words, the left word first, then the right word.
- R4: A PCM source with divider N (0 acts as 1) takes a new sample on the first tick after it is enabled and then on every Nth mixed tick. On the ticks in between it repeats its last sample.
- R5: A disabled source contributes 0 to the mix. Writes to a disabled PCM source's FIFO are dropped.
- R6: On a tick where an enabled PCM source is due for a sample and its FIFO holds too few words, no output is produced, no source takes data, and status bit 0 becomes 1. The next tick that finds all due sources supplied mixes normally and returns status bit 0 to 0.
- R7: Writing 1 to a flush bit empties that FIFO. The bit reads 1 in the cycle after the write and 0 from the cycle after that.
- R8: `dma_req[i]` is high while PCM source i is enabled and its FIFO level is at or below its threshold. `irq` is high when a request has its enable bit set, or when the stall flag is set and bit 5 of the interrupt enables is set.
- R9: `out_req` is high only while the output FIFO holds data and the remaining count is non-zero. Each acknowledged request removes one entry and lowers the count by one, so exactly the programmed number of transfers is delivered.
- R10: Enabling a source while mixing is running leaves the remaining transfer count unchanged, and the source takes part from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| pcm_wr_valid | input | 5 | Per-source FIFO write strobe |
| pcm_wr_data | input | 80 | Per-source FIFO write word, 16 bits each, source 0 in the low bits |
| wg_sample | input | 80 | Waveform-generator samples, 16 bits each, source 0 in the low bits |
| mix_tick | input | 1 | Mix strobe, one cycle per mix instant |
| dma_req | output | 5 | Per-source refill request |
| out_req | output | 1 | Mixed sample available and count not exhausted |
| out_ack | input | 1 | Consumer takes the offered sample |
| out_data | output | 32 | Offered sample: left in bits 31:16, right in bits 15:0 |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with both FIFO depths set to 4 and keeps the other defaults: five sources of each kind, a 4-bit divider and a 16-bit transfer count. The short FIFOs make the 3-bit threshold field cover every possible fill level, so a request can be watched rising and falling within a few writes. Sums of two full-scale samples reach both clamp limits. The divider and stall cases each need only a handful of ticks.

// File: rtl/mix_pkg.sv
// Shared constants for the PCM mixer: sample width and register word addresses.
// Assumes a 4-bit word address and a 32-bit data word on the register port.
package mix_pkg;
    localparam int SAMPLE_W = 16;
    localparam int REG_AW   = 4;
    localparam int REG_DW   = 32;

    typedef enum logic [REG_AW-1:0] {
        RA_CH_EN  = 4'd0,
        RA_STEREO = 4'd1,
        RA_FLUSH  = 4'd2,
        RA_XFER   = 4'd3,
        RA_IRQ_EN = 4'd4,
        RA_STATUS = 4'd5,
        RA_CFG0   = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/mix_fifo.sv
// First-word-fall-through FIFO that can pop one or two words per cycle.
// Assumes DEPTH is a power of two (at least 2) and that the caller never pops more
// than the current level. A write to a full FIFO is dropped. clr empties it and wins
// over any write or pop in the same cycle.
module mix_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [1:0]    pop_n,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok;

    assign wr_ok = wr_en && (level != LW'(DEPTH));
    assign rd0   = mem[rp];
    assign rd1   = mem[rp + AW'(1)];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(wr_ok);
            rp    <= rp + AW'(pop_n);
            level <= level + LW'(wr_ok) - LW'(pop_n);
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0)); // R7
endmodule

// File: rtl/mix_regs.sv
// Register file of the mixer: source enables, stereo selects, self-clearing flush bits,
// remaining transfer count, interrupt enables and the per-source divider and threshold.
// Assumes LVL_W <= 8 and DIV_W <= 8, so both settings fit in one data word.
module mix_regs
    import mix_pkg::*;
#(
    parameter int N_PCM = 5,
    parameter int N_WG  = 5,
    parameter int DIV_W = 4,
    parameter int LVL_W = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [REG_AW-1:0]      addr,
    input  logic [REG_DW-1:0]      wdata,
    output logic [REG_DW-1:0]      rdata,
    input  logic                   stall,
    input  logic                   xfer_dec,
    output logic [N_PCM-1:0]       en_pcm,
    output logic [N_WG-1:0]        en_wg,
    output logic [N_PCM-1:0]       stereo,
    output logic [N_PCM-1:0]       flush_pcm,
    output logic                   flush_out,
    output logic [N_PCM-1:0]       irq_en_dma,
    output logic                   irq_en_stall,
    output logic [N_PCM*DIV_W-1:0] div_flat,
    output logic [N_PCM*LVL_W-1:0] thr_flat,
    output logic [CNT_W-1:0]       remaining
);
    localparam int NEN = N_PCM + N_WG;

    logic [NEN-1:0]   en_q;
    logic [N_PCM:0]   flush_q;
    logic [N_PCM:0]   irq_en_q;
    logic [DIV_W-1:0] div_q [N_PCM];
    logic [LVL_W-1:0] thr_q [N_PCM];
    logic             wr_flush, wr_xfer, wr_en_reg;

    assign wr_flush  = we && (addr == RA_FLUSH);
    assign wr_xfer   = we && (addr == RA_XFER);
    assign wr_en_reg = we && (addr == RA_CH_EN);

    // Control register writes; flush bits last one cycle, the count drops on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            stereo    <= '0;
            flush_q   <= '0;
            irq_en_q  <= '0;
            remaining <= '0;
        end else begin
            flush_q <= wr_flush ? wdata[N_PCM:0] : '0;
            if (xfer_dec) remaining <= remaining - CNT_W'(1);
            if (wr_xfer)  remaining <= wdata[CNT_W-1:0];
            if (wr_en_reg) en_q <= wdata[NEN-1:0];
            if (we && addr == RA_STEREO) stereo   <= wdata[N_PCM-1:0];
            if (we && addr == RA_IRQ_EN) irq_en_q <= wdata[N_PCM:0];
        end
    end

    // Per-source divider and threshold writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_PCM; i++) begin
            if (!rst_n) begin
                div_q[i] <= '0;
                thr_q[i] <= '0;
            end else if (we && int'(addr) == int'(RA_CFG0) + i) begin
                div_q[i] <= wdata[DIV_W-1:0];
                thr_q[i] <= wdata[8 +: LVL_W];
            end
        end
    end

    // Combinational read-back of the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_CH_EN:  rdata[NEN-1:0]   = en_q;
            RA_STEREO: rdata[N_PCM-1:0] = stereo;
            RA_FLUSH:  rdata[N_PCM:0]   = flush_q;
            RA_XFER:   rdata[CNT_W-1:0] = remaining;
            RA_IRQ_EN: rdata[N_PCM:0]   = irq_en_q;
            RA_STATUS: rdata[0]         = stall;
            default: begin
                for (int i = 0; i < N_PCM; i++) begin
                    if (int'(addr) == int'(RA_CFG0) + i) begin
                        rdata[DIV_W-1:0]  = div_q[i];
                        rdata[8 +: LVL_W] = thr_q[i];
                    end
                end
            end
        endcase
    end

    assign en_pcm       = en_q[N_PCM-1:0];
    assign en_wg        = en_q[NEN-1:N_PCM];
    assign flush_pcm    = flush_q[N_PCM-1:0];
    assign flush_out    = flush_q[N_PCM];
    assign irq_en_dma   = irq_en_q[N_PCM-1:0];
    assign irq_en_stall = irq_en_q[N_PCM];

    for (genvar g = 0; g < N_PCM; g++) begin : g_flat
        assign div_flat[g*DIV_W +: DIV_W] = div_q[g];
        assign thr_flat[g*LVL_W +: LVL_W] = thr_q[g];
    end

    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_q) && !wr_flush |=> (flush_q == '0)); // R7
    AST_JOIN_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_reg && !wr_xfer && !xfer_dec |=> (remaining == $past(remaining))); // R10
endmodule

// File: rtl/mix_pcm_chan.sv
// One buffered PCM source: input FIFO, rate phase counter, mono or stereo unpacking,
// and hold of the last sample. It reports whether it is due and starved on this tick,
// and takes data only when the top grants a mixed tick (go).
// Assumes go is never asserted while any due source is starved.
module mix_pcm_chan #(
    parameter int SW    = 16,
    parameter int DEPTH = 8,
    parameter int DIV_W = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 stereo,
    input  logic [DIV_W-1:0]     div,
    input  logic [LW-1:0]        thr,
    input  logic                 flush,
    input  logic                 wr_valid,
    input  logic [SW-1:0]        wr_data,
    input  logic                 go,
    output logic                 starve,
    output logic                 dma_req,
    output logic signed [SW-1:0] mix_l,
    output logic signed [SW-1:0] mix_r
);
    logic [SW-1:0]    rd0, rd1;
    logic [LW-1:0]    level;
    logic [DIV_W-1:0] phase, div_eff;
    logic [1:0]       pop_n;
    logic             due, take;
    logic signed [SW-1:0] held_l, held_r;

    assign due     = en && (phase == '0);
    assign starve  = due && (level < (stereo ? LW'(2) : LW'(1)));
    assign take    = go && due;
    assign pop_n   = take ? (stereo ? 2'd2 : 2'd1) : 2'd0;
    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign dma_req = en && (level <= thr);

    mix_fifo #(.W(SW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .wr_en(wr_valid && en), .wr_data(wr_data),
        .pop_n(pop_n), .rd0(rd0), .rd1(rd1), .level(level)
    );

    // Rate phase: restart when idle, count down on each mixed tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || flush) phase <= '0;
        else if (go) phase <= (phase == '0) ? div_eff - DIV_W'(1) : phase - DIV_W'(1);
    end

    // Hold the last sample taken so it repeats between rate slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_l <= '0;
            held_r <= '0;
        end else if (take) begin
            held_l <= signed'(rd0);
            held_r <= stereo ? signed'(rd1) : signed'(rd0);
        end
    end

    // Contribution to this tick's sum: a fresh sample when due, else the held one.
    always_comb begin
        if (!en) begin
            mix_l = '0;
            mix_r = '0;
        end else if (due) begin
            mix_l = signed'(rd0);
            mix_r = stereo ? signed'(rd1) : signed'(rd0);
        end else begin
            mix_l = held_l;
            mix_r = held_r;
        end
    end

    AST_DISABLED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !flush |=> (level <= $past(level))); // R5
endmodule

// File: rtl/pcm_mixer.sv
// Top of the mixer. Buffered PCM sources and waveform-generator buses are summed with
// saturation on each mix_tick, unless a due source is starved (global stall) or the
// output FIFO is full. Mixed pairs leave through a request/acknowledge port that is
// limited by a programmed transfer count.
// Assumes mix_tick is a single-cycle strobe and that FIFO depths are powers of two.
module pcm_mixer
    import mix_pkg::*;
#(
    parameter int N_PCM     = 5,
    parameter int N_WG      = 5,
    parameter int PCM_DEPTH = 8,
    parameter int OUT_DEPTH = 8,
    parameter int DIV_W     = 4,
    parameter int CNT_W     = 16,
    localparam int SW       = SAMPLE_W,
    localparam int LVL_W    = $clog2(PCM_DEPTH + 1),
    localparam int OLW      = $clog2(OUT_DEPTH + 1),
    localparam int ACC_W    = SW + $clog2(N_PCM + N_WG) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic [N_PCM-1:0]    pcm_wr_valid,
    input  logic [N_PCM*SW-1:0] pcm_wr_data,
    input  logic [N_WG*SW-1:0]  wg_sample,
    input  logic                mix_tick,
    output logic [N_PCM-1:0]    dma_req,
    output logic                out_req,
    input  logic                out_ack,
    output logic [2*SW-1:0]     out_data,
    output logic                irq
);
    logic [N_PCM-1:0]       en_pcm, stereo, flush_pcm, irq_en_dma, starve;
    logic [N_WG-1:0]        en_wg;
    logic                   flush_out, irq_en_stall, stall_q, go, any_starve, out_full, xfer_dec;
    logic [N_PCM*DIV_W-1:0] div_flat;
    logic [N_PCM*LVL_W-1:0] thr_flat;
    logic [CNT_W-1:0]       remaining;
    logic [OLW-1:0]         out_level;
    logic [2*SW-1:0]        out_rd1;
    logic signed [SW-1:0]   ch_l [N_PCM];
    logic signed [SW-1:0]   ch_r [N_PCM];
    logic signed [ACC_W-1:0] acc_l, acc_r;
    logic [SW-1:0]          sat_l, sat_r;

    mix_regs #(.N_PCM(N_PCM), .N_WG(N_WG), .DIV_W(DIV_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .stall(stall_q), .xfer_dec(xfer_dec),
        .en_pcm(en_pcm), .en_wg(en_wg), .stereo(stereo), .flush_pcm(flush_pcm),
        .flush_out(flush_out), .irq_en_dma(irq_en_dma), .irq_en_stall(irq_en_stall),
        .div_flat(div_flat), .thr_flat(thr_flat), .remaining(remaining)
    );

    for (genvar g = 0; g < N_PCM; g++) begin : g_chan
        mix_pcm_chan #(.SW(SW), .DEPTH(PCM_DEPTH), .DIV_W(DIV_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_pcm[g]), .stereo(stereo[g]),
            .div(div_flat[g*DIV_W +: DIV_W]), .thr(thr_flat[g*LVL_W +: LVL_W]),
            .flush(flush_pcm[g]), .wr_valid(pcm_wr_valid[g]),
            .wr_data(pcm_wr_data[g*SW +: SW]), .go(go), .starve(starve[g]),
            .dma_req(dma_req[g]), .mix_l(ch_l[g]), .mix_r(ch_r[g])
        );
    end

    assign any_starve = |starve;
    assign out_full   = (out_level == OLW'(OUT_DEPTH));
    assign go         = mix_tick && !any_starve && !out_full;

    // Wide sums of every enabled source for both sides.
    always_comb begin
        acc_l = '0;
        acc_r = '0;
        for (int i = 0; i < N_PCM; i++) begin
            acc_l = acc_l + ACC_W'(ch_l[i]);
            acc_r = acc_r + ACC_W'(ch_r[i]);
        end
        for (int i = 0; i < N_WG; i++) begin
            if (en_wg[i]) begin
                acc_l = acc_l + ACC_W'(signed'(wg_sample[i*SW +: SW]));
                acc_r = acc_r + ACC_W'(signed'(wg_sample[i*SW +: SW]));
            end
        end
    end

    // Clamp a wide sum to the sample range.
    function automatic logic [SW-1:0] clamp(input logic signed [ACC_W-1:0] v);
        logic [ACC_W-SW:0] hi;
        hi = v[ACC_W-1:SW-1];
        if ((&hi) || !(|hi)) return v[SW-1:0];
        return v[ACC_W-1] ? {1'b1, {(SW-1){1'b0}}} : {1'b0, {(SW-1){1'b1}}};
    endfunction

    assign sat_l = clamp(acc_l);
    assign sat_r = clamp(acc_r);

    mix_fifo #(.W(2*SW), .DEPTH(OUT_DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n), .clr(flush_out), .wr_en(go),
        .wr_data({sat_l, sat_r}), .pop_n({1'b0, xfer_dec}),
        .rd0(out_data), .rd1(out_rd1), .level(out_level)
    );

    assign out_req  = (out_level != '0) && (remaining != '0);
    assign xfer_dec = out_req && out_ack;

    // Stall flag: set by a starved tick, cleared by the next tick that mixes.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else if (mix_tick && any_starve) stall_q <= 1'b1;
        else if (go) stall_q <= 1'b0;
    end

    assign irq = (|(dma_req & irq_en_dma)) || (stall_q && irq_en_stall);

    AST_STALL_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        mix_tick && any_starve && !flush_out |=> (out_level <= $past(out_level))); // R6
    AST_STALL_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mix_tick && any_starve |=> stall_q); // R6
    AST_COUNT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        out_req && out_ack && (remaining == CNT_W'(1)) && !(reg_we && reg_addr == RA_XFER)
        |=> !out_req); // R9
endmodule

// File: tb/pcm_mixer_bench.sv
// Directed bench for pcm_mixer: one task per scenario, each checking its own results.
module pcm_mixer_bench;
    import mix_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int NW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pcm_wr_valid = '0;
    logic [NP*16-1:0] pcm_wr_data = '0;
    logic [NW*16-1:0] wg_sample = '0;
    logic          mix_tick = 1'b0;
    logic [NP-1:0] dma_req;
    logic          out_req;
    logic          out_ack = 1'b0;
    logic [31:0]   out_data;
    logic          irq;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_mixer #(.PCM_DEPTH(4), .OUT_DEPTH(4)) u_pcm_mixer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pcm_wr_valid(pcm_wr_valid),
        .pcm_wr_data(pcm_wr_data), .wg_sample(wg_sample), .mix_tick(mix_tick),
        .dma_req(dma_req), .out_req(out_req), .out_ack(out_ack),
        .out_data(out_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; step(); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic push(input int ch, input logic [15:0] d);
        pcm_wr_valid[ch] = 1'b1; pcm_wr_data[ch*16 +: 16] = d; step(); pcm_wr_valid[ch] = 1'b0;
    endtask

    task automatic tick();
        mix_tick = 1'b1; step(); mix_tick = 1'b0;
    endtask

    task automatic pull(input string req, input logic [15:0] el, input logic [15:0] er);
        chk(req, {31'b0, out_req}, 32'd1);
        chk(req, {16'b0, out_data[31:16]}, {16'b0, el});
        chk(req, {16'b0, out_data[15:0]}, {16'b0, er});
        out_ack = 1'b1; step(); out_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(RA_CH_EN, d);  chk("R1 enables", d, 0);
        rd(RA_STATUS, d); chk("R1 status", d, 0);
        rd(RA_XFER, d);   chk("R1 count", d, 0);
        chk("R1 out_req", {31'b0, out_req}, 0);
        chk("R1 dma_req", {27'b0, dma_req}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_sum();
        do_reset();
        wg_sample = '0; wg_sample[15:0] = 16'd7;
        wr(RA_CH_EN, 32'h23);           // pcm0, pcm1, wg0
        wr(RA_XFER, 32'd10);
        push(0, 16'd100); push(1, -16'sd50); tick(); pull("R2 plain sum", 16'd57, 16'd57);
        push(0, 16'd30000); push(1, 16'd30000); tick(); pull("R2 clamp high", 16'h7FFF, 16'h7FFF);
        push(0, -16'sd30000); push(1, -16'sd30000); tick(); pull("R2 clamp low", 16'h8000, 16'h8000);
    endtask

    task automatic t_stereo();
        do_reset();
        wr(RA_STEREO, 32'h4); wr(RA_CH_EN, 32'h4); wr(RA_XFER, 32'd4);
        push(2, 16'd1000); push(2, 16'd2000); tick(); pull("R3 stereo pair", 16'd1000, 16'd2000);
        wr(RA_STEREO, 32'h0); push(2, 16'd321); tick(); pull("R3 mono both sides", 16'd321, 16'd321);
    endtask

    task automatic t_rate();
        do_reset();
        wr(RA_CFG0 + 3, 32'h3); wr(RA_CH_EN, 32'h8); wr(RA_XFER, 32'd8);
        push(3, 16'd10); push(3, 16'd20);
        tick(); pull("R4 first slot", 16'd10, 16'd10);
        tick(); pull("R4 held 1", 16'd10, 16'd10);
        tick(); pull("R4 held 2", 16'd10, 16'd10);
        tick(); pull("R4 next slot", 16'd20, 16'd20);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        do_reset();
        wg_sample = '0; wg_sample[31:16] = 16'd999;   // wg1 stays disabled
        wr(RA_CH_EN, 32'h2); wr(RA_XFER, 32'd4);
        push(1, 16'd40); push(0, 16'd77);
        tick(); pull("R5 disabled adds zero", 16'd40, 16'd40);
        wr(RA_CH_EN, 32'h3); push(1, 16'd41); tick();
        rd(RA_STATUS, d); chk("R5 write to disabled dropped", d, 1);
        chk("R5 no output", {31'b0, out_req}, 0);
    endtask

    task automatic t_stall();
        logic [31:0] d;
        do_reset();
        wr(RA_IRQ_EN, 32'h20); wr(RA_CH_EN, 32'h3); wr(RA_XFER, 32'd4);
        push(0, 16'd100); tick();
        rd(RA_STATUS, d); chk("R6 stall flag", d, 1);
        chk("R6 no output on stall", {31'b0, out_req}, 0);
        chk("R8 stall irq", {31'b0, irq}, 1);
        push(1, 16'd5); tick();
        rd(RA_STATUS, d); chk("R6 resume clears flag", d, 0);
        pull("R6 nothing consumed during stall", 16'd105, 16'd105);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        do_reset();
        wr(RA_CH_EN, 32'h1); wr(RA_XFER, 32'd4);
        push(0, 16'd11); push(0, 16'd12);
        wr(RA_FLUSH, 32'h1);
        rd(RA_FLUSH, d); chk("R7 bit reads 1", d, 1);
        step();
        rd(RA_FLUSH, d); chk("R7 bit self-clears", d, 0);
        tick();
        rd(RA_STATUS, d); chk("R7 fifo emptied", d, 1);
    endtask

    task automatic t_dma();
        do_reset();
        wr(RA_CFG0, 32'h101); wr(RA_IRQ_EN, 32'h1); wr(RA_CH_EN, 32'h1);
        chk("R8 req at low level", {27'b0, dma_req}, 32'h1);
        chk("R8 irq from req", {31'b0, irq}, 1);
        push(0, 16'd1);
        chk("R8 req at threshold", {27'b0, dma_req}, 32'h1);
        push(0, 16'd2);
        chk("R8 req drops above threshold", {27'b0, dma_req}, 32'h0);
        chk("R8 irq drops", {31'b0, irq}, 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        do_reset();
        wg_sample = '0; wg_sample[15:0] = 16'd3;
        wr(RA_CH_EN, 32'h20); wr(RA_XFER, 32'd2);
        tick(); tick(); tick();
        pull("R9 transfer 1", 16'd3, 16'd3);
        pull("R9 transfer 2", 16'd3, 16'd3);
        chk("R9 stops after count", {31'b0, out_req}, 0);
        rd(RA_XFER, d); chk("R9 count exhausted", d, 0);
    endtask

    task automatic t_join();
        logic [31:0] d;
        do_reset();
        wg_sample = '0; wg_sample[15:0] = 16'd3;
        wr(RA_CH_EN, 32'h20); wr(RA_XFER, 32'd5);
        tick(); pull("R10 before join", 16'd3, 16'd3);
        wr(RA_CH_EN, 32'h21);
        rd(RA_XFER, d); chk("R10 count kept", d, 4);
        push(0, 16'd10); tick(); pull("R10 joined source mixes", 16'd13, 16'd13);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step();
        t_reset(); t_sum(); t_stereo(); t_rate(); t_disabled();
        t_stall(); t_flush(); t_dma(); t_count(); t_join();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule